// File: doc/BRIEF.md
# USB Host Frame Timer

This block paces the 1 ms frames of a full-speed USB host controller. It counts 12 MHz bit-time strobes, and at the end of every frame interval it raises a one-clock start-of-frame pulse and steps an 11-bit frame number. The interval is a fixed base of 11936 ticks plus a 7-bit software trim, which is 12000 ticks after reset. The frame number also serves as the index into a frame list held in memory. The block combines the number with a page-aligned list base to give the word address of the current list entry.

Software drives a simple write port that selects one of four registers: control (run/stop), frame number, list base and trim. The current register values, the entry address and a halted status are plain outputs. Stopping takes effect only when the current frame ends. Starting takes effect one clock after the write, and the first frame after a start always has full length.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset, halted is 1, sof_pulse is 0, frame_num is 0, sof_trim is 64 and list_base is 0.
- R2: While running, the spacing between start-of-frame pulses is 11936 plus the trim value in tick strobes (12000 with trim 64, 11936 with trim 0, 12063 with trim 127).
- R3: At each frame boundary sof_pulse is high for exactly one clock, and in that same clock frame_num shows the previous value plus one modulo 2048 (0x7FF is followed by 0x000).
- R4: A write with wr_sel=3 stores wr_data[6:0] as the trim; sof_trim[7] always reads 0.
- R5: A write with wr_sel=1 stores wr_data[10:0] as the frame number only while halted is 1, and is ignored while running; frame_num[15:11] always read 0.
- R6: A write with wr_sel=2 stores wr_data[31:12] as the list base; list_base[11:0] always read 0.
- R7: entry_addr equals {list_base[31:12], frame_num[9:0], 2'b00}.
- R8: A write with wr_sel=0 and wr_data[0]=0 stops the timer: halted stays 0 until the end of the current frame, rises together with that frame's sof_pulse, and afterwards no pulse occurs and frame_num does not change.
- R9: A write with wr_sel=0 and wr_data[0]=1 clears halted one clock after the write edge. The tick counter restarts from zero on every 0-to-1 change of run, so the next pulse comes one full frame after the restart, also when run is dropped and raised again inside a frame.
- R10: Clocks with tick_en low do not advance the tick counter and stretch the frame by their number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-clock strobe per 12 MHz bit time |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 frame number, 2 list base, 3 trim |
| wr_data | input | 32 | Write data |
| frame_num | output | 16 | Frame number readback, bits 15-11 zero |
| sof_trim | output | 8 | Trim readback, bit 7 zero |
| list_base | output | 32 | Frame list base readback, bits 11-0 zero |
| entry_addr | output | 32 | Word address of the current frame list entry |
| halted | output | 1 | Timer is halted |
| sof_pulse | output | 1 | One-clock start-of-frame pulse |

## Verification
Some properties are checked on every clock. Each pulse is a single cycle and coincides with a frame number step of one, modulo 2048. The frame number stays put while running between pulses. The reserved bits stay zero, halted rises only together with a pulse, and a halted timer given run clears halted on the next clock. The exact frame lengths for the various trim values, the stretching by idle tick strobes, and the rule that a frame number write is refused while running can only be shown by the bench's directed scenarios. The same holds for the full-length frame after a start or after a restart inside a frame, and for the composed entry address.

// File: rtl/usb_frame_pkg.sv
// Package: shared register select codes and default timing constants for
// the USB host frame timer. Assumes a 2-bit register select.
package usb_frame_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_FNUM = 2'd1,
        SEL_BASE = 2'd2,
        SEL_TRIM = 2'd3
    } ufr_sel_e;

    localparam int unsigned DEF_FRAME_BASE = 11936;
    localparam int unsigned DEF_TRIM_RESET = 64;
endpackage

// File: rtl/ufr_regs.sv
// Module: software register bank for run/stop, frame trim and list base.
// Assumes writes arrive as single-cycle strobes; the frame number register
// lives in ufr_fnum because its write is gated by the halted state.
module ufr_regs
    import usb_frame_pkg::*;
#(
    parameter int unsigned TRIM_W    = 7,
    parameter int unsigned TRIM_RST  = 64,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PAGE_BITS = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_sel,
    input  logic                          wr_run,
    input  logic [TRIM_W-1:0]             wr_trim,
    input  logic [ADDR_W-PAGE_BITS-1:0]   wr_base,
    output logic                          run_q,
    output logic [TRIM_W-1:0]             trim_q,
    output logic [ADDR_W-PAGE_BITS-1:0]   base_q
);
    logic sel_ctrl;
    logic sel_trim;
    logic sel_base;

    // Decode the register select into per-register write enables.
    always_comb begin
        sel_ctrl = wr_en && (wr_sel == SEL_CTRL);
        sel_trim = wr_en && (wr_sel == SEL_TRIM);
        sel_base = wr_en && (wr_sel == SEL_BASE);
    end

    // Hold the run bit, the trim value and the page-aligned list base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            trim_q <= TRIM_W'(TRIM_RST);
            base_q <= '0;
        end else begin
            if (sel_ctrl) run_q  <= wr_run;
            if (sel_trim) trim_q <= wr_trim;
            if (sel_base) base_q <= wr_base;
        end
    end
endmodule

// File: rtl/ufr_counter.sv
// Module: frame tick counter and halt state machine.
// Counts tick strobes while not halted; at the last tick of a frame it
// wraps, pulses sof and, if run is low, enters halted. A rising run bit
// restarts the count so the following frame has full length.
module ufr_counter #(
    parameter int unsigned FRAME_BASE = 11936,
    parameter int unsigned TRIM_W     = 7,
    localparam int unsigned CNT_W     = $clog2(FRAME_BASE + (1 << TRIM_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              run,
    input  logic [TRIM_W-1:0] trim,
    output logic              halted_q,
    output logic              sof_q,
    output logic              frame_end
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             run_prev_q;
    logic             run_rise;
    logic             at_last;

    // Frame length and last-tick detection against the live trim value.
    always_comb begin
        last_cnt  = CNT_W'(FRAME_BASE) + CNT_W'(trim) - CNT_W'(1);
        at_last   = (cnt_q >= last_cnt);
        run_rise  = run && !run_prev_q;
        frame_end = !halted_q && tick_en && at_last && !run_rise;
    end

    // Advance or reload the tick count and raise the frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            sof_q      <= 1'b0;
            run_prev_q <= 1'b0;
        end else begin
            run_prev_q <= run;
            sof_q      <= frame_end;
            if (run_rise) begin
                cnt_q <= '0;
            end else if (!halted_q && tick_en) begin
                cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
            end
        end
    end

    // Halted: set at a frame end with run low, cleared once run is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted_q <= 1'b1;
        end else if (halted_q && run) begin
            halted_q <= 1'b0;
        end else if (frame_end && !run) begin
            halted_q <= 1'b1;
        end
    end
endmodule

// File: rtl/ufr_fnum.sv
// Module: frame number register. Software may load it only while halted;
// otherwise it steps by one (natural wrap) at every frame end.
module ufr_fnum #(
    parameter int unsigned FNUM_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fnum,
    input  logic [FNUM_W-1:0] wr_value,
    input  logic              halted,
    input  logic              frame_end,
    output logic [FNUM_W-1:0] fnum_q
);
    // Load when halted, step at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fnum_q <= '0;
        end else if (wr_fnum && halted) begin
            fnum_q <= wr_value;
        end else if (frame_end) begin
            fnum_q <= fnum_q + FNUM_W'(1);
        end
    end
endmodule

// File: rtl/ufr_addr.sv
// Module: frame list entry address. Each entry is one 32-bit word, so the
// low frame number bits index words inside the page given by the base.
module ufr_addr #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PAGE_BITS = 12,
    localparam int unsigned IDX_W    = PAGE_BITS - 2
) (
    input  logic [ADDR_W-PAGE_BITS-1:0] base,
    input  logic [IDX_W-1:0]            index,
    output logic [ADDR_W-1:0]           entry
);
    // Concatenate page, word index and byte offset.
    always_comb begin
        entry = {base, index, 2'b00};
    end
endmodule

// File: rtl/usb_frame_timer.sv
// Module: top of the USB host frame timer. Wires the register bank, the
// tick counter, the frame number register and the entry address logic.
// Assumes tick_en is a one-clock strobe per 12 MHz bit time and that
// FNUM_W is at least PAGE_BITS-2.
module usb_frame_timer
    import usb_frame_pkg::*;
#(
    parameter int unsigned FRAME_BASE = DEF_FRAME_BASE,
    parameter int unsigned TRIM_W     = 7,
    parameter int unsigned TRIM_RST   = DEF_TRIM_RESET,
    parameter int unsigned FNUM_W     = 11,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_BITS  = 12,
    localparam int unsigned REG_W     = 16,
    localparam int unsigned TRIM_REG_W = TRIM_W + 1,
    localparam int unsigned BASE_W    = ADDR_W - PAGE_BITS,
    localparam int unsigned IDX_W     = PAGE_BITS - 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_en,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [ADDR_W-1:0]     wr_data,
    output logic [REG_W-1:0]      frame_num,
    output logic [TRIM_REG_W-1:0] sof_trim,
    output logic [ADDR_W-1:0]     list_base,
    output logic [ADDR_W-1:0]     entry_addr,
    output logic                  halted,
    output logic                  sof_pulse
);
    logic              run_q;
    logic [TRIM_W-1:0] trim_q;
    logic [BASE_W-1:0] base_q;
    logic [FNUM_W-1:0] fnum_q;
    logic              frame_end;
    logic              wr_fnum;
    logic              unused_wr_bits;

    // Frame number write strobe and a sink for data bits no register keeps.
    always_comb begin
        wr_fnum        = wr_en && (wr_sel == SEL_FNUM);
        unused_wr_bits = ^wr_data;
    end

    ufr_regs #(
        .TRIM_W    (TRIM_W),
        .TRIM_RST  (TRIM_RST),
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_run  (wr_data[0]),
        .wr_trim (wr_data[TRIM_W-1:0]),
        .wr_base (wr_data[ADDR_W-1:PAGE_BITS]),
        .run_q   (run_q),
        .trim_q  (trim_q),
        .base_q  (base_q)
    );

    ufr_counter #(
        .FRAME_BASE (FRAME_BASE),
        .TRIM_W     (TRIM_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .run       (run_q),
        .trim      (trim_q),
        .halted_q  (halted),
        .sof_q     (sof_pulse),
        .frame_end (frame_end)
    );

    ufr_fnum #(
        .FNUM_W (FNUM_W)
    ) u_fnum (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_fnum   (wr_fnum),
        .wr_value  (wr_data[FNUM_W-1:0]),
        .halted    (halted),
        .frame_end (frame_end),
        .fnum_q    (fnum_q)
    );

    ufr_addr #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_addr (
        .base  (base_q),
        .index (fnum_q[IDX_W-1:0]),
        .entry (entry_addr)
    );

    // Readback views with reserved bits held at zero.
    always_comb begin
        frame_num = REG_W'(fnum_q);
        sof_trim  = TRIM_REG_W'(trim_q);
        list_base = {base_q, {PAGE_BITS{1'b0}}};
    end
endmodule

// File: rtl/ufr_checker.sv
// Module: property checker for usb_frame_timer, attached by bind.
// Assumes the default widths of the top module.
module ufr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        run,
    input logic [15:0] frame_num,
    input logic [7:0]  sof_trim,
    input logic [31:0] list_base,
    input logic [31:0] entry_addr,
    input logic        halted,
    input logic        sof_pulse
);
    // R3
    sof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |=> !sof_pulse);

    // R3
    fnum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> (frame_num == (($past(frame_num) + 16'd1) & 16'h07FF)));

    // R5
    fnum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(halted) && !sof_pulse) |-> $stable(frame_num));

    // R5
    fnum_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_num[15:11] == 5'd0);

    // R4
    trim_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_trim[7]);

    // R6
    base_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        list_base[11:0] == 12'd0);

    // R7
    entry_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_addr[31:12] == list_base[31:12]) && (entry_addr[1:0] == 2'b00));

    // R8
    halt_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> sof_pulse);

    // R8
    halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted)) |-> !sof_pulse);

    // R9
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && halted) |=> !halted);
endmodule

bind usb_frame_timer ufr_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_q),
    .frame_num  (frame_num),
    .sof_trim   (sof_trim),
    .list_base  (list_base),
    .entry_addr (entry_addr),
    .halted     (halted),
    .sof_pulse  (sof_pulse)
);

// File: tb/usb_frame_timer_tb.sv
// Bench: directed scenarios for usb_frame_timer, one task per scenario.
module usb_frame_timer_tb;
    logic        clk;
    logic        rst_n;
    logic        tick_en;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic [15:0] frame_num;
    logic [7:0]  sof_trim;
    logic [31:0] list_base;
    logic [31:0] entry_addr;
    logic        halted;
    logic        sof_pulse;

    int errors = 0;
    int checks = 0;
    logic [10:0] exp_fn = '0;
    logic [31:0] exp_base = '0;

    usb_frame_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .frame_num  (frame_num),
        .sof_trim   (sof_trim),
        .list_base  (list_base),
        .entry_addr (entry_addr),
        .halted     (halted),
        .sof_pulse  (sof_pulse)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        check(act == exp, req, what, act, exp);
    endtask

    // Write one register; called at a negedge, returns at the next negedge.
    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Count negedges until sof_pulse is seen; track the expected frame number.
    task automatic wait_sof(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!sof_pulse);
        exp_fn = exp_fn + 11'd1;
    endtask

    function automatic logic [31:0] exp_entry();
        return {exp_base[31:12], exp_fn[9:0], 2'b00};
    endfunction

    task automatic t_reset();
        check_eq("R1", "halted after reset", 32'(halted), 32'd1);
        check_eq("R1", "sof after reset", 32'(sof_pulse), 32'd0);
        check_eq("R1", "frame after reset", 32'(frame_num), 32'd0);
        check_eq("R1", "trim after reset", 32'(sof_trim), 32'd64);
        check_eq("R1", "base after reset", list_base, 32'd0);
    endtask

    task automatic t_regs();
        wr(2'd3, 32'hFF);
        check_eq("R4", "trim masked to 7 bits", 32'(sof_trim), 32'h7F);
        wr(2'd1, 32'hFFFF);
        check_eq("R5", "frame write while halted", 32'(frame_num), 32'h7FF);
        wr(2'd2, 32'hFFFF_FFFF);
        check_eq("R6", "base low bits zero", list_base, 32'hFFFF_F000);
        check_eq("R7", "entry address all ones", entry_addr, 32'hFFFF_FFFC);
        wr(2'd2, 32'h1234_5ABC);
        exp_base = 32'h1234_5000;
        check_eq("R6", "base write", list_base, exp_base);
        wr(2'd1, 32'h155);
        check_eq("R7", "entry address mixed", entry_addr, 32'h1234_5554);
        wr(2'd3, 32'd64);
        check_eq("R4", "trim back to 64", 32'(sof_trim), 32'd64);
        wr(2'd1, 32'h7FE);
        exp_fn = 11'h7FE;
    endtask

    task automatic t_start();
        int k;
        wr(2'd0, 32'd1);
        check_eq("R9", "halted in write cycle", 32'(halted), 32'd1);
        @(negedge clk);
        check_eq("R9", "halted cleared next cycle", 32'(halted), 32'd0);
        wait_sof(k);
        check_eq("R9", "first frame full length", 32'(k), 32'd12000);
        check_eq("R3", "frame number step", 32'(frame_num), 32'(exp_fn));
        check_eq("R7", "entry at 0x7FF", entry_addr, exp_entry());
        @(negedge clk);
        check_eq("R3", "pulse lasts one clock", 32'(sof_pulse), 32'd0);
        wait_sof(k);
        check_eq("R2", "default frame length", 32'(k + 1), 32'd12000);
        check_eq("R3", "frame number wraps", 32'(frame_num), 32'd0);
        check_eq("R7", "entry at frame 0", entry_addr, exp_base);
    endtask

    task automatic t_locked_and_trim();
        int k;
        wr(2'd1, 32'h100);
        check_eq("R5", "frame write ignored while running", 32'(frame_num), 32'(exp_fn));
        wr(2'd3, 32'd0);
        wait_sof(k);
        check_eq("R2", "frame length trim 0", 32'(k + 2), 32'd11936);
        check_eq("R5", "frame count unaffected by write", 32'(frame_num), 32'(exp_fn));
        wr(2'd3, 32'd127);
        wait_sof(k);
        check_eq("R2", "frame length trim 127", 32'(k + 1), 32'd12063);
    endtask

    task automatic t_tick_gate();
        int k;
        wr(2'd3, 32'd64);
        tick_en = 1'b0;
        repeat (500) @(negedge clk);
        check_eq("R10", "no pulse while ticks idle", 32'(sof_pulse), 32'd0);
        tick_en = 1'b1;
        wait_sof(k);
        check_eq("R10", "frame stretched by idle clocks", 32'(k + 501), 32'd12500);
    endtask

    task automatic t_stop();
        int k;
        int pulses;
        logic [15:0] held;
        wr(2'd0, 32'd0);
        check_eq("R8", "still running after stop write", 32'(halted), 32'd0);
        wait_sof(k);
        check_eq("R8", "stop waits for frame end", 32'(k + 1), 32'd12000);
        check_eq("R8", "halted at frame end", 32'(halted), 32'd1);
        check_eq("R8", "last frame counted", 32'(frame_num), 32'(exp_fn));
        held = frame_num;
        pulses = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (sof_pulse) pulses++;
        end
        check_eq("R8", "no pulses while halted", 32'(pulses), 32'd0);
        check_eq("R8", "frame frozen while halted", 32'(frame_num), 32'(held));
        wr(2'd1, 32'h3);
        exp_fn = 11'h3;
        check_eq("R5", "frame write accepted after halt", 32'(frame_num), 32'h3);
    endtask

    task automatic t_restart();
        int k;
        wr(2'd0, 32'd1);
        @(negedge clk);
        check_eq("R9", "halted cleared on restart", 32'(halted), 32'd0);
        wait_sof(k);
        check_eq("R9", "restart frame full length", 32'(k), 32'd12000);
        check_eq("R3", "frame after restart", 32'(frame_num), 32'(exp_fn));
        repeat (100) @(negedge clk);
        wr(2'd0, 32'd0);
        wr(2'd0, 32'd1);
        check_eq("R9", "quick stop-start keeps running", 32'(halted), 32'd0);
        wait_sof(k);
        check_eq("R9", "count reloaded on run rise", 32'(k), 32'd12001);
        check_eq("R7", "entry after reload", entry_addr, exp_entry());
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        tick_en = 1'b1;
        wr_en   = 1'b0;
        wr_sel  = 2'd0;
        wr_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_start();
        t_locked_and_trim();
        t_tick_gate();
        t_stop();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule